// File: doc/BRIEF.md
# Drive Ready Monitor With Timeout

This block waits for a disk drive to become ready for its next operation, with a timeout that the caller sets. After a `start` pulse it watches three active-low lines from the drive: seek finished, drive ready and drive selected. Readiness counts only when all three are low, and they must still be low on a second look taken a short fixed delay later. This second look rejects lines that do not all settle at the same moment. If readiness is never confirmed before the elapsed-cycle counter reaches the limit, the wait ends with a ready-error flag.

Every wait ends with a one-cycle `done` pulse. At that moment the block also latches a snapshot of the drive's status lines. The write-fault bit in that snapshot can come from either of two input pins, chosen by a board-variant select. It always lands at the same bit position. All drive inputs pass through a two-flop synchronizer before any decision uses them. A limit of zero selects a long built-in default of 1,600,000,000 cycles.

Top module: `drive_ready_watch`

## Requirements
- R1: During and right after reset, `busy_o`, `done_o` and `rdy_err_o` are 0 and `status_o` is 4'b0000.
- R2: When the three active-low lines have been low and steady for a while before `start_i`, `done_o` rises after the 9th rising edge that follows the edge sampling `start_i`, with `rdy_err_o` = 0. That is 2 edges plus a confirm delay of 7.
- R3: If any of the three lines is high at the confirming second sample, the block does not report ready. It keeps polling, and it reports ready only after a later pair of samples that both see all three lines low.
- R4: The elapsed counter clears at the edge that samples `start_i`. When readiness is never confirmed, `done_o` rises with `rdy_err_o` = 1 after edge limit+1, counting from that start edge. A timeout that falls inside the confirm delay also ends the wait with an error.
- R5: A `limit_i` of 0 selects the default limit of 1,600,000,000 cycles, so the wait is still busy and has no `done_o` 100 cycles after start.
- R6: `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle. `rdy_err_o` holds its value from `done_o` until the next start.
- R7: `status_o` is latched when `done_o` rises and holds until the next completion. Its bit 0 is the seek-finished line, bit 1 the ready line, bit 2 the select line (all raw levels, 1 = high), and bit 3 is the write-fault level.
- R8: With `wf_sel_i` = 0 the write-fault bit comes from `wfault_a_i`; with `wf_sel_i` = 1 it comes from `wfault_b_i`.
- R9: A `start_i` pulse while `busy_o` is high has no effect on the running wait or on when it ends.
- R10: If confirmation succeeds in the same cycle that the counter reaches the limit, the result is ready (no error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a wait when idle |
| limit_i | input | 32 | Timeout limit in cycles, latched at start; 0 selects the default |
| wf_sel_i | input | 1 | Write-fault source select: 0 = pin A, 1 = pin B |
| seek_done_ni | input | 1 | Seek finished, active low, asynchronous |
| drv_ready_ni | input | 1 | Drive ready, active low, asynchronous |
| drv_sel_ni | input | 1 | Drive selected, active low, asynchronous |
| wfault_a_i | input | 1 | Write-fault line, source A |
| wfault_b_i | input | 1 | Write-fault line, source B |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdy_err_o | output | 1 | Timeout flag, valid with `done_o` |
| status_o | output | 4 | Snapshot of the drive lines at completion |

## Verification
The hardest case to reach from the ports is a line that looks good on the first sample and has gone bad by the confirming one. The stimulus lowers all three lines well ahead of start. It then raises the ready line three edges into the confirm delay, so that the synchronized value is high exactly at the second sample. It is then lowered again at a known edge, and the exact late completion edge shows that polling resumed. A second corner puts the timeout limit inside the confirm delay, and a third makes it coincide with the confirming edge.

// File: rtl/drm_pkg.sv
package drm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POLL   = 2'd1,
        ST_SETTLE = 2'd2
    } state_e;

    // Order of the synchronized line vector
    localparam int LN_SEEK  = 0;
    localparam int LN_RDY   = 1;
    localparam int LN_SEL   = 2;
    localparam int LN_WF_A  = 3;
    localparam int LN_WF_B  = 4;
    localparam int LN_COUNT = 5;

    // Snapshot layout
    localparam int ST_W      = 4;
    localparam int ST_WF_BIT = 3;

endpackage

// File: rtl/drm_sync.sv
module drm_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    generate
        if (STAGES < 1) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [W-1:0] chain_d [STAGES];
            logic [W-1:0] chain_q [STAGES];

            always_comb begin
                for (int s = 0; s < STAGES; s++) begin
                    if (s == 0) chain_d[s] = async_i;
                    else        chain_d[s] = chain_q[s-1];
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
                end else begin
                    for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
                end
            end

            assign sync_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/drm_tmo_cnt.sv
module drm_tmo_cnt #(
    parameter int CW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i && (cnt_q < limit_i)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q >= limit_i);

    AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0)); // R4

    AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && run_i && expired_o) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/drm_settle_tmr.sv
module drm_settle_tmr #(
    parameter int CYC = 7
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic zero_o
);

    localparam int DW = $clog2(CYC + 1);
    localparam logic [DW-1:0] LOAD_VAL = DW'(CYC);

    logic [DW-1:0] tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i)             tmr_d = LOAD_VAL;
        else if (tmr_q != '0)   tmr_d = tmr_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign zero_o = (tmr_q == '0);

    AST_SETTLE_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !zero_o); // R2

endmodule

// File: rtl/drive_ready_watch.sv
module drive_ready_watch
    import drm_pkg::*;
#(
    parameter int              TMO_W       = 32,
    parameter logic [TMO_W-1:0] DFLT_LIMIT  = TMO_W'(1_600_000_000),
    parameter int              CONFIRM_CYC = 7,
    parameter int              SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [TMO_W-1:0] limit_i,
    input  logic             wf_sel_i,
    input  logic             seek_done_ni,
    input  logic             drv_ready_ni,
    input  logic             drv_sel_ni,
    input  logic             wfault_a_i,
    input  logic             wfault_b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             rdy_err_o,
    output logic [ST_W-1:0]  status_o
);

    // Idle levels: active-low lines high, fault lines low
    localparam logic [LN_COUNT-1:0] LINE_RST = LN_COUNT'(5'b00111);

    typedef struct packed {
        state_e           st;
        logic [TMO_W-1:0] lim;
        logic             done;
        logic             err;
        logic [ST_W-1:0]  stat;
    } core_t;

    core_t d, q;

    logic [LN_COUNT-1:0] lines_raw, lines_s;
    logic                all_low;
    logic                wf_bit;
    logic [ST_W-1:0]     snap;
    logic [TMO_W-1:0]    lim_eff;
    logic                tmo_clr, tmo_run, tmo_expired;
    logic                tmr_load, tmr_zero;

    assign lines_raw[LN_SEEK] = seek_done_ni;
    assign lines_raw[LN_RDY]  = drv_ready_ni;
    assign lines_raw[LN_SEL]  = drv_sel_ni;
    assign lines_raw[LN_WF_A] = wfault_a_i;
    assign lines_raw[LN_WF_B] = wfault_b_i;

    drm_sync #(
        .W       (LN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINE_RST)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (lines_raw),
        .sync_o  (lines_s)
    );

    drm_tmo_cnt #(
        .CW (TMO_W)
    ) u_tmo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (tmo_clr),
        .run_i     (tmo_run),
        .limit_i   (q.lim),
        .expired_o (tmo_expired)
    );

    drm_settle_tmr #(
        .CYC (CONFIRM_CYC)
    ) u_settle (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .zero_o (tmr_zero)
    );

    always_comb begin
        all_low = ~(lines_s[LN_SEEK] | lines_s[LN_RDY] | lines_s[LN_SEL]);
        wf_bit  = wf_sel_i ? lines_s[LN_WF_B] : lines_s[LN_WF_A];
        snap    = '0;
        snap[LN_SEEK]   = lines_s[LN_SEEK];
        snap[LN_RDY]    = lines_s[LN_RDY];
        snap[LN_SEL]    = lines_s[LN_SEL];
        snap[ST_WF_BIT] = wf_bit;
        lim_eff = (limit_i == '0) ? DFLT_LIMIT : limit_i;
    end

    assign tmo_run = (q.st != ST_IDLE);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmo_clr  = 1'b0;
        tmr_load = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_POLL;
                    d.lim   = lim_eff;
                    d.err   = 1'b0;
                    tmo_clr = 1'b1;
                end
            end
            ST_POLL: begin
                if (tmo_expired) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.stat = snap;
                end else if (all_low) begin
                    d.st     = ST_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero && all_low) begin
                    // confirmation wins over a coinciding timeout
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.err  = 1'b0;
                    d.stat = snap;
                end else if (tmo_expired) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.stat = snap;
                end else if (tmr_zero) begin
                    d.st = ST_POLL;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, lim: '0, done: 1'b0, err: 1'b0, stat: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;
    assign rdy_err_o = q.err;
    assign status_o  = q.stat;

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R6

    AST_IDLE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R6

    AST_OK_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !rdy_err_o) |-> (status_o[2:0] == 3'b000)); // R2

    AST_OK_FROM_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !rdy_err_o) |-> ($past(q.st) == ST_SETTLE)); // R3

    AST_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !done_o && !start_i) |=> $stable(rdy_err_o)); // R6

    AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(q.lim)); // R9

endmodule

// File: tb/drive_ready_watch_bench.sv
module drive_ready_watch_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] limit;
    logic        wf_sel;
    logic        seek_n, rdy_n, sel_n;
    logic        wfa, wfb;
    logic        busy, done, err;
    logic [3:0]  status;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    drive_ready_watch u_drive_ready_watch (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .limit_i      (limit),
        .wf_sel_i     (wf_sel),
        .seek_done_ni (seek_n),
        .drv_ready_ni (rdy_n),
        .drv_sel_ni   (sel_n),
        .wfault_a_i   (wfa),
        .wfault_b_i   (wfb),
        .busy_o       (busy),
        .done_o       (done),
        .rdy_err_o    (err),
        .status_o     (status)
    );

    typedef struct packed {
        logic [2:0]  lvl;   // {sel, rdy, seek}
        logic        wa;
        logic        wb;
        logic        ws;
        logic [15:0] lim;
        logic        xerr;
        logic [7:0]  xlat;
        logic [3:0]  xst;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 1'b0, 1'b0, 1'b0, 16'd50, 1'b0, 8'd9,  4'b0000}, // R2
        '{3'b000, 1'b1, 1'b0, 1'b0, 16'd50, 1'b0, 8'd9,  4'b1000}, // R8 pin A
        '{3'b000, 1'b1, 1'b0, 1'b1, 16'd50, 1'b0, 8'd9,  4'b0000}, // R8 pin B chosen
        '{3'b000, 1'b0, 1'b1, 1'b1, 16'd50, 1'b0, 8'd9,  4'b1000}, // R8 pin B
        '{3'b001, 1'b0, 1'b0, 1'b0, 16'd20, 1'b1, 8'd21, 4'b0001}, // R4 seek high
        '{3'b010, 1'b0, 1'b0, 1'b0, 16'd12, 1'b1, 8'd13, 4'b0010}, // R4 rdy high
        '{3'b100, 1'b0, 1'b1, 1'b1, 16'd5,  1'b1, 8'd6,  4'b1100}, // R4 R7
        '{3'b111, 1'b0, 1'b0, 1'b0, 16'd1,  1'b1, 8'd2,  4'b0111}, // R4 all high
        '{3'b000, 1'b0, 1'b0, 1'b0, 16'd3,  1'b1, 8'd4,  4'b0000}, // R4 inside delay
        '{3'b000, 1'b0, 1'b0, 1'b0, 16'd8,  1'b0, 8'd9,  4'b0000}  // R10 tie
    };

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_lines(input logic [2:0] lvl, input logic a, input logic b,
                             input logic s);
        sel_n  = lvl[2];
        rdy_n  = lvl[1];
        seek_n = lvl[0];
        wfa    = a;
        wfb    = b;
        wf_sel = s;
    endtask

    // Pulse start; returns after the edge that samples it
    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Counts edges after the start edge until done is seen
    task automatic wait_done(input int maxn, output int n, output logic seen);
        seen = 1'b0;
        n    = 0;
        for (int k = 1; k <= maxn; k++) begin
            @(negedge clk);
            if (done && !seen) begin
                seen = 1'b1;
                n    = k;
                break;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int   n;
        logic seen;
        logic [3:0] st_hold;
        logic       err_hold;

        rst_n = 1'b0;
        start = 1'b0;
        limit = 32'd50;
        set_lines(3'b111, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(err == 1'b0, "R1", "err in reset", err, 0);
        check(status == 4'b0000, "R1", "status in reset", status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", busy, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            set_lines(VECS[v].lvl, VECS[v].wa, VECS[v].wb, VECS[v].ws);
            limit = 32'(VECS[v].lim);
            repeat (6) @(negedge clk);
            pulse_start();
            wait_done(int'(VECS[v].lim) + 40, n, seen);
            check(seen, VECS[v].xerr ? "R4" : "R2", "done seen", seen, 1);
            check(n == int'(VECS[v].xlat), VECS[v].xerr ? "R4" : "R2",
                  "done latency", n, int'(VECS[v].xlat));
            check(err == VECS[v].xerr, v == 9 ? "R10" : "R4", "error flag", err,
                  VECS[v].xerr);
            check(status == VECS[v].xst, "R7 R8", "status snapshot", status,
                  VECS[v].xst);
            check(busy == 1'b0, "R6", "busy low with done", busy, 0);
            st_hold  = status;
            err_hold = err;
            // R6 pulse ends, R7 snapshot and flag hold while inputs move
            set_lines(~VECS[v].lvl, ~VECS[v].wa, ~VECS[v].wb, VECS[v].ws);
            @(negedge clk);
            check(done == 1'b0, "R6", "done one cycle", done, 0);
            repeat (4) @(negedge clk);
            check(err == err_hold, "R6", "err held", err, err_hold);
            check(status == st_hold, "R7", "status held", status, st_hold);
        end

        // R3: ready line goes high inside the confirm window
        set_lines(3'b000, 1'b0, 1'b0, 1'b0);
        limit = 32'd30;
        repeat (6) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        rdy_n = 1'b1;
        wait_done(60, n, seen);
        n = n + 3;
        check(n == 31, "R3", "glitch timeout latency", n, 31);
        check(err == 1'b1, "R3", "glitch gives error", err, 1);
        check(status == 4'b0010, "R3", "glitch status", status, 4'b0010);

        // R3: glitch then recovery; polling resumes and confirms later
        set_lines(3'b000, 1'b0, 1'b0, 1'b0);
        limit = 32'd100;
        repeat (6) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        rdy_n = 1'b1;
        repeat (9) @(negedge clk);
        check(done == 1'b0, "R3", "no done before recovery", done, 0);
        rdy_n = 1'b0;
        wait_done(60, n, seen);
        n = n + 12;
        check(n == 23, "R3", "recovery latency", n, 23);
        check(err == 1'b0, "R3", "recovery ok", err, 0);

        // R9: second start while busy is ignored
        set_lines(3'b000, 1'b0, 1'b0, 1'b0);
        limit = 32'd50;
        repeat (6) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        limit = 32'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(40, n, seen);
        n = n + 4;
        check(n == 9, "R9", "latency unchanged", n, 9);
        check(err == 1'b0, "R9", "no error from restart", err, 0);

        // R5: zero limit selects the long default
        set_lines(3'b111, 1'b0, 1'b0, 1'b0);
        limit = 32'd0;
        repeat (6) @(negedge clk);
        pulse_start();
        wait_done(100, n, seen);
        check(seen == 1'b0, "R5", "no done in 100 cycles", seen, 0);
        check(busy == 1'b1, "R5", "still busy", busy, 1);

        // R1: reset aborts the wait
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && status == 4'b0000, "R1", "reset clears wait", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule